// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches a set of asynchronous interrupt lines, brings each one into the clock domain through a two-flop synchroniser, and detects the rising and falling edges that software has enabled for each line. A detected edge latches a pending flag. Software clears that flag by writing a 1 to it. Software can also force a line pending through a software-trigger register. One combined interrupt request is the OR of every pending line that is unmasked. A separate per-line event output gives a one-cycle pulse for lines whose event mask is set.

The host reaches six 32-bit registers through a plain register port. The port has a word index, a write strobe, write data and combinational read data. Lines 0 to 16 and 18 to 22 exist. Line 17 and bits 31:23 are reserved holes.

Register indices, where index = byte offset / 4:

| Index | Register |
|-------|----------|
| 0 | interrupt mask |
| 1 | event mask |
| 2 | rising enable |
| 3 | falling enable |
| 4 | software trigger |
| 5 | pending |

Top module: `ext_irq_ctrl`

## Requirements
- R1: Bit 17 and bits 31:23 of every register read as 0. Writes to those bits have no effect, and line 17 never becomes pending.
- R2: All six registers reset to 0. The index map is 0 interrupt mask, 1 event mask, 2 rising enable, 3 falling enable, 4 software trigger, 5 pending. Indices 6 and 7 read 0. The mask and enable registers read back the value written, with the reserved bits forced to 0.
- R3: An input edge that is enabled for a line sets that line's pending bit on the third rising clock after the input changes. If both rising and falling are enabled for a line, each of the two edges sets pending.
- R4: A line held at a steady level sets no pending bit after it is cleared. An edge whose enable bit is 0 sets no pending bit.
- R5: Writing 1 to a software-trigger bit that reads 0 sets that bit on the next clock. If the line's interrupt mask bit is 1, the same write also sets the line's pending bit. If the mask bit is 0, the pending bit is not set. Writing 0 to a software-trigger bit leaves it unchanged. The bit clears only when a 1 is written to the matching pending bit.
- R6: Writing 1 to a pending bit clears it. Writing 0 to a pending bit leaves it unchanged.
- R7: `irq` is 1 exactly when some line has both its pending bit and its interrupt mask bit at 1.
- R8: `evt[n]` pulses high for one cycle when line n has its event mask bit at 1 and either an enabled edge is detected or a software-trigger bit goes from 0 to 1. The pulse comes on the same clock at which pending would be set. The event path never sets a pending bit.
- R9: A falling edge whose detection coincides with a write to the falling-enable register does not set pending.
- R10: If an edge and a write-1-to-clear reach the same pending bit on the same clock, the pending bit stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 23 | Asynchronous interrupt lines |
| reg_idx | input | 3 | Register word index |
| wr_en | input | 1 | Write strobe; the write takes effect on the rising clock edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `reg_idx` (combinational) |
| irq | output | 1 | Combined interrupt request |
| evt | output | 23 | One-cycle event pulses, one bit per line |

## Verification
The bench times each line edge to the exact third clock, to catch a synchroniser that is one flop short or long. It clears a pending bit while the input is held steady; a level-sensitive design would set the bit again at once.

It places a write to the falling-enable register on the very cycle a falling edge is detected, and checks that the edge is dropped. A following clean fall must still register, which catches a design that ignores falls altogether.

It also lands a clear on the same clock as a new edge, where a clear-wins design would lose the interrupt. It checks that software-trigger bits survive a write of 0 and that masked software triggers leave pending at 0.

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int NLINES   = 23,
  parameter int GAP_LINE = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] line_in,
  input  logic [2:0]        reg_idx,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq,
  output logic [NLINES-1:0] evt
);
  localparam logic [NLINES-1:0] LMASK  = ~(NLINES'(1) << GAP_LINE);
  localparam logic [31:0]       IMPL32 = 32'(LMASK);
  localparam logic [2:0] A_IM = 3'd0, A_EV = 3'd1, A_RT = 3'd2,
                         A_FT = 3'd3, A_SW = 3'd4, A_PD = 3'd5;

  logic [31:0] imr, emr, rtr, ftr, swr, pnd;
  logic [NLINES-1:0] s1, s2, s3;
  logic [NLINES-1:0] wd, rise, fall, trig, sw_new, clr, pnd_n, swr_n;
  logic w_im, w_ev, w_rt, w_ft, w_sw, w_pd;

  assign w_im = wr_en && reg_idx == A_IM;
  assign w_ev = wr_en && reg_idx == A_EV;
  assign w_rt = wr_en && reg_idx == A_RT;
  assign w_ft = wr_en && reg_idx == A_FT;
  assign w_sw = wr_en && reg_idx == A_SW;
  assign w_pd = wr_en && reg_idx == A_PD;

  assign wd     = wdata[NLINES-1:0] & LMASK;
  assign rise   = s2 & ~s3 & rtr[NLINES-1:0];
  assign fall   = ~s2 & s3 & ftr[NLINES-1:0] & {NLINES{~w_ft}};
  assign trig   = (rise | fall) & LMASK;
  assign sw_new = w_sw ? (wd & ~swr[NLINES-1:0]) : '0;
  assign clr    = w_pd ? wd : '0;
  assign pnd_n  = (pnd[NLINES-1:0] & ~clr) | trig | (sw_new & imr[NLINES-1:0]);
  assign swr_n  = (swr[NLINES-1:0] & ~clr) | sw_new;
  assign irq    = |(pnd & imr);

  always_comb begin
    case (reg_idx)
      A_IM:    rdata = imr;
      A_EV:    rdata = emr;
      A_RT:    rdata = rtr;
      A_FT:    rdata = ftr;
      A_SW:    rdata = swr;
      A_PD:    rdata = pnd;
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr <= '0; emr <= '0; rtr <= '0; ftr <= '0; swr <= '0; pnd <= '0;
      s1 <= '0; s2 <= '0; s3 <= '0; evt <= '0;
    end else begin
      if (w_im) imr <= wdata & IMPL32;
      if (w_ev) emr <= wdata & IMPL32;
      if (w_rt) rtr <= wdata & IMPL32;
      if (w_ft) ftr <= wdata & IMPL32;
      swr <= 32'(swr_n);
      pnd <= 32'(pnd_n);
      evt <= (trig | sw_new) & emr[NLINES-1:0];
      s1  <= line_in;
      s2  <= s1;
      s3  <= s2;
    end
  end

  assert_resv_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~IMPL32) == 32'd0);

  assert_level_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && s2 == s3) |=> $stable(pnd));

  assert_sw_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && reg_idx == A_PD) |=> ((swr & $past(swr)) == $past(swr)));

  assert_irq_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pnd != 32'd0));

  assert_evt_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & ~$past(emr[NLINES-1:0])) == '0);
endmodule

// File: tb/sim_ext_irq_ctrl.sv
module sim_ext_irq_ctrl;
  logic        clk = 0, rst_n = 0, wr_en = 0, irq;
  logic [22:0] line_in = '0, evt;
  logic [2:0]  reg_idx = '0;
  logic [31:0] wdata = '0, rdata;
  int nvec = 0, nbad = 0;

  localparam logic [2:0] IM = 0, EV = 1, RT = 2, FT = 3, SW = 4, PD = 5;

  ext_irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .line_in(line_in), .reg_idx(reg_idx),
                   .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq), .evt(evt));

  always #5 clk = ~clk;

  localparam int NV = 6;
  localparam logic [66:0] VEC [NV] = '{
    {3'd0, 32'hFFFF_FFFF, 32'h007D_FFFF},
    {3'd1, 32'h0002_0000, 32'h0000_0000},
    {3'd2, 32'h1234_5678, 32'h0034_5678},
    {3'd3, 32'hFFFE_0001, 32'h007C_0001},
    {3'd6, 32'hFFFF_FFFF, 32'h0000_0000},
    {3'd7, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] i, logic [31:0] d);
    @(negedge clk); reg_idx = i; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [2:0] i, logic [31:0] exp, string tag);
    reg_idx = i; #1; chk(tag, rdata, exp);
  endtask

  task automatic edge_wait(int b, logic v);
    @(negedge clk); line_in[b] = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    nvec++; nbad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int i = 0; i < 6; i++) rd(3'(i), 0, "R2 reset value");
    chk("R7 irq at reset", {31'd0, irq}, 0);
    chk("R8 evt at reset", {9'd0, evt}, 0);
    rst_n = 1;

    for (int k = 0; k < NV; k++) begin
      wr(VEC[k][66:64], VEC[k][63:32]);
      rd(VEC[k][66:64], VEC[k][31:0], "R1 R2 readback");
    end
    for (int i = 0; i < 4; i++) wr(3'(i), 0);

    // R3 rising edge, then R4 steady level and a disabled fall
    wr(IM, 1 << 5); wr(RT, 1 << 5);
    edge_wait(5, 1);
    rd(PD, 1 << 5, "R3 rise sets pending on third clock");
    chk("R7 irq with unmasked pending", {31'd0, irq}, 1);
    wr(PD, 1 << 5);
    repeat (5) @(negedge clk);
    rd(PD, 0, "R4 steady level no retrigger");
    chk("R7 irq low after clear", {31'd0, irq}, 0);
    edge_wait(5, 0); @(negedge clk);
    rd(PD, 0, "R4 disabled fall ignored");

    // R3 both edges on line 6
    wr(RT, (1 << 5) | (1 << 6)); wr(FT, 1 << 6);
    edge_wait(6, 1);
    rd(PD, 1 << 6, "R3 both enabled, rise");
    wr(PD, 0);
    rd(PD, 1 << 6, "R6 write 0 keeps pending");
    wr(PD, 1 << 6);
    rd(PD, 0, "R6 write 1 clears");
    edge_wait(6, 0);
    rd(PD, 1 << 6, "R3 both enabled, fall");
    wr(PD, 1 << 6);

    // R7 pending without mask
    wr(RT, (1 << 5) | (1 << 6) | (1 << 7));
    edge_wait(7, 1);
    rd(PD, 1 << 7, "R7 masked line still pends");
    chk("R7 irq low when masked", {31'd0, irq}, 0);
    wr(IM, (1 << 5) | (1 << 7)); #1;
    chk("R7 irq on unmask", {31'd0, irq}, 1);
    wr(PD, 1 << 7);

    // R8 event pulses
    wr(EV, 1 << 8); wr(RT, 1 << 8);
    @(negedge clk); line_in[8] = 1;
    repeat (3) @(negedge clk); #1;
    chk("R8 edge event pulse", {9'd0, evt}, 1 << 8);
    @(negedge clk); #1;
    chk("R8 event lasts one cycle", {9'd0, evt}, 0);
    wr(PD, 1 << 8);
    wr(SW, 1 << 8); #1;
    chk("R8 sw event pulse", {9'd0, evt}, 1 << 8);
    rd(PD, 0, "R8 event path sets no pending (masked line)");
    @(negedge clk); #1;
    chk("R8 sw event ends", {9'd0, evt}, 0);
    wr(PD, 1 << 8);
    rd(SW, 0, "R5 sw bit cleared via pending clear");

    // R5 software trigger
    wr(IM, 1 << 3); wr(SW, 1 << 3);
    rd(PD, 1 << 3, "R5 sw trigger sets pending");
    rd(SW, 1 << 3, "R5 sw bit reads set");
    wr(SW, 0);
    rd(SW, 1 << 3, "R5 write 0 keeps sw bit");
    wr(PD, 1 << 3);
    rd(SW, 0, "R5 pending clear drops sw bit");
    rd(PD, 0, "R6 sw pending cleared");
    wr(SW, 1 << 4);
    rd(PD, 0, "R5 masked sw sets no pending");
    rd(SW, 1 << 4, "R5 masked sw bit held");
    wr(PD, 1 << 4);
    wr(SW, 1 << 17);
    rd(SW, 0, "R1 reserved sw bit");

    // R1 line 17 never pends
    wr(RT, 32'hFFFF_FFFF); wr(IM, 0);
    edge_wait(17, 1); @(negedge clk);
    rd(PD, 0, "R1 line 17 never pends");
    wr(RT, 0);

    // R9 fall during falling-enable write is dropped
    wr(FT, 1 << 9);
    edge_wait(9, 1);
    @(negedge clk); line_in[9] = 0;
    repeat (2) @(negedge clk);
    reg_idx = FT; wdata = 1 << 9; wr_en = 1;
    @(negedge clk); wr_en = 0;
    rd(PD, 0, "R9 fall with falling-enable write dropped");
    edge_wait(9, 1);
    edge_wait(9, 0);
    rd(PD, 1 << 9, "R9 clean fall still pends");
    wr(PD, 1 << 9); wr(FT, 0);

    // R10 edge beats simultaneous clear
    wr(RT, 1 << 10);
    edge_wait(10, 1);
    edge_wait(10, 0);
    rd(PD, 1 << 10, "R10 setup pending");
    @(negedge clk); line_in[10] = 1;
    repeat (2) @(negedge clk);
    reg_idx = PD; wdata = 1 << 10; wr_en = 1;
    @(negedge clk); wr_en = 0;
    rd(PD, 1 << 10, "R10 edge wins over clear");
    wr(PD, 1 << 10);
    rd(PD, 0, "R10 later clear works");

    finish_run();
  end
endmodule